// File: doc/BRIEF.md
# Passive-Parallel Configuration Init Sequencer

This block is a state machine that prepares a target programmable device for passive-parallel configuration. It is started by a single-cycle pulse. It first checks the mode-select value and waits for the target's configuration-request and status lines to be released. It then steps the control outputs through a fixed order: a known idle drive, then the override settings, then chip select. After that it runs a configuration-request low/high handshake, in which each edge must be answered by the status line. It then does a sanity check on the configuration-done pin and its output enable. When every step passes, it turns on the configuration data and control paths. Streaming of configuration data is outside the block.

Every wait has a timeout of `TIMEOUT_CYC` clock cycles; the default corresponds to one second at 125 MHz. The block ends every run with a one-cycle `done_o` pulse and a result code that holds until the next run. Any failure puts the outputs into a safe state: all override-disable bits set, chip select released, both paths off, and the request line high. All pin inputs must already be synchronous to `clk`.

Top module: `cfg_init_seq`

## Requirements
- R1: A start pulse when idle with any `mode_sel_i` bit above bit 0 set ends at once. `done_o` rises the next cycle with result 2 (bad mode), and `busy_o` is never raised. Values 0 and 1 let the sequence proceed.
- R2: Before driving anything, the block waits for `ncfg_pin_i` and `nstat_pin_i` to be high together. If either stays low, the run ends with result 3 (timeout) after exactly `TIMEOUT_CYC` busy cycles.
- R3: The outputs change in this order: idle drive first (chip-select-n 1, request 0, paths off, `ncfg_o` 1, output enables 0), then the overrides (config and request override-disable cleared, status and done override-disable set), then chip-select-n low, then a second release wait. `ncfg_o` is driven low only after all of this.
- R4: `ncfg_o` stays low until `nstat_pin_i` is seen low, and then returns high. If the status line never goes low within `TIMEOUT_CYC` cycles of waiting, the result is 3.
- R5: After `ncfg_o` returns high, the block waits for `nstat_pin_i` high. If it does not come back within `TIMEOUT_CYC` cycles, the result is 3.
- R6: After the handshake, the run succeeds only if `cdone_pin_i` is 0 and `cdone_oe_i` is 1. Any other combination gives result 4 (done-check error).
- R7: On success the result is 1, and both `cfg_data_en_o` and `cfg_ctrl_en_o` rise with `done_o`. Chip select stays asserted and the overrides stay applied. With the ready lines high and a status response D cycles after the request falls, the run is busy for D+8 cycles.
- R8: Every failing run leaves chip-select-n 1, all four override-disable outputs 1, both paths 0, `ncfg_o` 1 and output enables 0.
- R9: `done_o` is high for exactly one cycle, and `result_o` holds until the next run ends. A start pulse while busy is ignored.
- R10: After reset the outputs are in the safe state of R8, and `busy_o`, `done_o` and `result_o` (0 = none) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_sel_i | input | MSEL_W | Mode-select value read from the target |
| ncfg_pin_i | input | 1 | Level of the configuration-request line |
| nstat_pin_i | input | 1 | Level of the status line |
| cdone_pin_i | input | 1 | Level of the configuration-done line |
| cdone_oe_i | input | 1 | Read-back of the configuration-done output enable |
| ncs_o | output | 1 | Chip select, active low |
| pr_req_o | output | 1 | Partial-reconfiguration request |
| cfg_ctrl_en_o | output | 1 | Configuration control path enable |
| cfg_data_en_o | output | 1 | Configuration data path enable |
| ncfg_o | output | 1 | Configuration request drive, active low |
| nstat_oe_o | output | 1 | Status line output enable |
| cdone_oe_o | output | 1 | Done line output enable |
| ovr_dis_cfg_o | output | 1 | Configuration override disable |
| ovr_dis_ncfg_o | output | 1 | Request-line override disable |
| ovr_dis_nstat_o | output | 1 | Status-line override disable |
| ovr_dis_cdone_o | output | 1 | Done-line override disable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | 3 | 0 none, 1 ok, 2 bad mode, 3 timeout, 4 done-check error |

## Verification
The bench sweeps every mode-select value and every status response delay from 0 up to the timeout. At the boundary (a delay of `TIMEOUT_CYC`-1 versus `TIMEOUT_CYC`), a design whose timeout comparison is off by one succeeds where it should time out, or the reverse. The bench also checks the exact busy length of each path, the order of output changes, and the safe state after each kind of failure. A sequencer that skipped a release wait, let go of the request line early, accepted a wrong done-pin combination or left an override enabled after an error would show up as a wrong cycle count, a wrong result code or a wrong output level.

// File: rtl/cfg_init_pkg.sv
package cfg_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REL1, ST_INIT, ST_OVR, ST_SEL, ST_REL2, ST_LO, ST_HI, ST_CHK
  } seq_st_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_INIT, CMD_OVR, CMD_SEL, CMD_NCFG_LO, CMD_NCFG_HI, CMD_ENABLE, CMD_SAFE
  } ctl_cmd_e;

  typedef enum logic [2:0] {
    RES_NONE     = 3'd0,
    RES_OK       = 3'd1,
    RES_BAD_MODE = 3'd2,
    RES_TIMEOUT  = 3'd3,
    RES_BAD_DONE = 3'd4
  } res_e;

  typedef struct packed {
    logic ncs;
    logic pr_req;
    logic ctrl_en;
    logic data_en;
    logic ncfg;
    logic nstat_oe;
    logic cdone_oe;
    logic od_cfg;
    logic od_ncfg;
    logic od_nstat;
    logic od_cdone;
  } ctl_t;

  function automatic ctl_t safe_ctl();
    ctl_t c;
    c.ncs      = 1'b1;
    c.pr_req   = 1'b0;
    c.ctrl_en  = 1'b0;
    c.data_en  = 1'b0;
    c.ncfg     = 1'b1;
    c.nstat_oe = 1'b0;
    c.cdone_oe = 1'b0;
    c.od_cfg   = 1'b1;
    c.od_ncfg  = 1'b1;
    c.od_nstat = 1'b1;
    c.od_cdone = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int LIMIT = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2

endmodule

// File: rtl/cfg_mode_check.sv
module cfg_mode_check #(
  parameter int MSEL_W = 3
) (
  input  logic [MSEL_W-1:0] mode_sel,
  output logic              accepted
);
  generate
    if (MSEL_W > 1) begin : g_wide
      assign accepted = ~|mode_sel[MSEL_W-1:1];
    end else begin : g_narrow
      assign accepted = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/cfg_ctl_bank.sv
module cfg_ctl_bank
  import cfg_init_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ctl_cmd_e cmd,
  output ctl_t     ctl
);
  ctl_t nxt;

  always_comb begin
    nxt = ctl;
    unique case (cmd)
      CMD_INIT: begin
        nxt.ncs      = 1'b1;
        nxt.pr_req   = 1'b0;
        nxt.ctrl_en  = 1'b0;
        nxt.data_en  = 1'b0;
        nxt.ncfg     = 1'b1;
        nxt.nstat_oe = 1'b0;
        nxt.cdone_oe = 1'b0;
      end
      CMD_OVR: begin
        nxt.od_cfg   = 1'b0;
        nxt.od_ncfg  = 1'b0;
        nxt.od_nstat = 1'b1;
        nxt.od_cdone = 1'b1;
      end
      CMD_SEL:     nxt.ncs  = 1'b0;
      CMD_NCFG_LO: nxt.ncfg = 1'b0;
      CMD_NCFG_HI: nxt.ncfg = 1'b1;
      CMD_ENABLE: begin
        nxt.ctrl_en = 1'b1;
        nxt.data_en = 1'b1;
      end
      CMD_SAFE: nxt = safe_ctl();
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ctl <= safe_ctl();
    else     ctl <= nxt;
  end

  AST_NCFG_LOW_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !ctl.ncfg |-> (!ctl.ncs && !ctl.od_ncfg && !ctl.od_cfg)); // R3

endmodule

// File: rtl/cfg_init_seq.sv
module cfg_init_seq
  import cfg_init_pkg::*;
#(
  parameter int MSEL_W      = 3,
  parameter int TIMEOUT_CYC = 125_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MSEL_W-1:0] mode_sel_i,
  input  logic              ncfg_pin_i,
  input  logic              nstat_pin_i,
  input  logic              cdone_pin_i,
  input  logic              cdone_oe_i,
  output logic              ncs_o,
  output logic              pr_req_o,
  output logic              cfg_ctrl_en_o,
  output logic              cfg_data_en_o,
  output logic              ncfg_o,
  output logic              nstat_oe_o,
  output logic              cdone_oe_o,
  output logic              ovr_dis_cfg_o,
  output logic              ovr_dis_ncfg_o,
  output logic              ovr_dis_nstat_o,
  output logic              ovr_dis_cdone_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        result_o
);
  localparam logic [MSEL_W-1:0] LOW_BIT = MSEL_W'(1);

  seq_st_e  st, nxt;
  ctl_cmd_e cmd;
  ctl_t     ctl;
  logic     fin, tmr_run, tmr_exp, mode_ok, lines_free;
  res_e     code;

  cfg_mode_check #(.MSEL_W(MSEL_W)) u_mode (
    .mode_sel (mode_sel_i),
    .accepted (mode_ok)
  );

  cfg_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  cfg_ctl_bank u_bank (
    .clk (clk),
    .rst (rst),
    .cmd (cmd),
    .ctl (ctl)
  );

  assign lines_free = ncfg_pin_i && nstat_pin_i;

  always_comb begin
    nxt     = st;
    cmd     = CMD_NONE;
    fin     = 1'b0;
    code    = RES_NONE;
    tmr_run = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start_i) begin
          if (mode_ok) nxt = ST_REL1;
          else begin
            fin  = 1'b1;
            code = RES_BAD_MODE;
            cmd  = CMD_SAFE;
          end
        end
      end
      ST_REL1, ST_REL2: begin
        if (lines_free) begin
          nxt = (st == ST_REL1) ? ST_INIT : ST_LO;
          if (st == ST_REL2) cmd = CMD_NCFG_LO;
        end else if (tmr_exp) begin
          nxt = ST_IDLE; fin = 1'b1; code = RES_TIMEOUT; cmd = CMD_SAFE;
        end else tmr_run = 1'b1;
      end
      ST_INIT: begin cmd = CMD_INIT; nxt = ST_OVR; end
      ST_OVR:  begin cmd = CMD_OVR;  nxt = ST_SEL; end
      ST_SEL:  begin cmd = CMD_SEL;  nxt = ST_REL2; end
      ST_LO: begin
        if (!nstat_pin_i) begin
          cmd = CMD_NCFG_HI; nxt = ST_HI;
        end else if (tmr_exp) begin
          nxt = ST_IDLE; fin = 1'b1; code = RES_TIMEOUT; cmd = CMD_SAFE;
        end else tmr_run = 1'b1;
      end
      ST_HI: begin
        if (nstat_pin_i) nxt = ST_CHK;
        else if (tmr_exp) begin
          nxt = ST_IDLE; fin = 1'b1; code = RES_TIMEOUT; cmd = CMD_SAFE;
        end else tmr_run = 1'b1;
      end
      ST_CHK: begin
        nxt = ST_IDLE;
        fin = 1'b1;
        if (!cdone_pin_i && cdone_oe_i) begin
          code = RES_OK; cmd = CMD_ENABLE;
        end else begin
          code = RES_BAD_DONE; cmd = CMD_SAFE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      result_o <= RES_NONE;
    end else begin
      st     <= nxt;
      busy_o <= (nxt != ST_IDLE);
      done_o <= fin;
      if (fin) result_o <= code;
    end
  end

  assign ncs_o           = ctl.ncs;
  assign pr_req_o        = ctl.pr_req;
  assign cfg_ctrl_en_o   = ctl.ctrl_en;
  assign cfg_data_en_o   = ctl.data_en;
  assign ncfg_o          = ctl.ncfg;
  assign nstat_oe_o      = ctl.nstat_oe;
  assign cdone_oe_o      = ctl.cdone_oe;
  assign ovr_dis_cfg_o   = ctl.od_cfg;
  assign ovr_dis_ncfg_o  = ctl.od_ncfg;
  assign ovr_dis_nstat_o = ctl.od_nstat;
  assign ovr_dis_cdone_o = ctl.od_cdone;

  AST_BAD_MODE_ABORT: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && ((mode_sel_i & ~LOW_BIT) != '0)) |=>
      (done_o && result_o == RES_BAD_MODE && !busy_o)); // R1

  AST_NCFG_RISE_ACKED: assert property (@(posedge clk) disable iff (rst)
    $rose(ncfg_o) |-> ($past(!nstat_pin_i) || (done_o && result_o == RES_TIMEOUT))); // R4

  AST_DONE_PINS_OK: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o == RES_OK) |-> $past(!cdone_pin_i && cdone_oe_i)); // R6

  AST_PATHS_ON_SUCCESS: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_data_en_o) |-> (done_o && result_o == RES_OK && cfg_ctrl_en_o && !ncs_o)); // R7

  AST_ERROR_SAFE: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o != RES_OK) |->
      (ncs_o && ncfg_o && !cfg_data_en_o && !cfg_ctrl_en_o &&
       ovr_dis_cfg_o && ovr_dis_ncfg_o && ovr_dis_nstat_o && ovr_dis_cdone_o)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

endmodule

// File: tb/cfg_init_seq_tb.sv
module cfg_init_seq_tb;
  localparam int MW = 3;
  localparam int TO = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [MW-1:0] msel = '0;
  logic ncfg_pin, nstat_pin, cdone_pin, cdone_oe;
  logic ncs, prq, cen, den, ncfg, nsoe, cdoe, odc, odn, ods, odd, busy, done;
  logic [2:0] res;

  // target model knobs
  logic ncfg_low_k = 0, stat_low_k = 0, hi_stuck_k = 0;
  int   dly_k = 0;
  int   lo_cnt = 0;
  logic seen_lo = 0;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign ncfg_pin  = !ncfg_low_k;
  assign nstat_pin = stat_low_k ? 1'b0 :
                     (hi_stuck_k && seen_lo) ? 1'b0 :
                     (ncfg ? 1'b1 : (lo_cnt < dly_k));

  always @(posedge clk) begin
    if (ncfg) lo_cnt <= 0; else lo_cnt <= lo_cnt + 1;
    seen_lo <= hi_stuck_k && (seen_lo || (!ncfg && lo_cnt >= dly_k));
  end

  cfg_init_seq #(.MSEL_W(MW), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .mode_sel_i(msel),
    .ncfg_pin_i(ncfg_pin), .nstat_pin_i(nstat_pin), .cdone_pin_i(cdone_pin),
    .cdone_oe_i(cdone_oe), .ncs_o(ncs), .pr_req_o(prq), .cfg_ctrl_en_o(cen),
    .cfg_data_en_o(den), .ncfg_o(ncfg), .nstat_oe_o(nsoe), .cdone_oe_o(cdoe),
    .ovr_dis_cfg_o(odc), .ovr_dis_ncfg_o(odn), .ovr_dis_nstat_o(ods),
    .ovr_dis_cdone_o(odd), .busy_o(busy), .done_o(done), .result_o(res)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int safe_word();
    return {ncs, prq, cen, den, ncfg, nsoe, cdoe, odc, odn, ods, odd};
  endfunction

  localparam int SAFE_W = 11'b10001001111;
  localparam int RUN_W  = 11'b00111000011;

  task automatic run(input int mode, input int dly, input bit nl, input bit sl,
                     input bit hs, input bit cd, input bit coe, input bit inject,
                     input int exp_res, input int exp_busy, input string req);
    int  bcnt = 0, lo_smp = 0, guard = 0;
    bit  ord_ok = 1;
    int  r_seen;
    @(negedge clk);
    msel = MW'(mode); dly_k = dly; ncfg_low_k = nl; stat_low_k = sl;
    hi_stuck_k = hs; cdone_pin = cd; cdone_oe = coe;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 200) begin
      if (busy) bcnt++;
      if (!ncfg) begin
        lo_smp++;
        // R3: request low only with select and overrides in place
        if (!(ncs == 0 && odc == 0 && odn == 0 && ods == 1 && odd == 1 &&
              prq == 0 && nsoe == 0 && cdoe == 0 && cen == 0 && den == 0))
          ord_ok = 0;
      end
      start = inject && (bcnt == 3);
      guard++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(guard < 200, req, "watchdog per run", guard, 200);
    chk(int'(res) == exp_res, req, "result code", res, exp_res);
    chk(bcnt == exp_busy, req, "busy cycles", bcnt, exp_busy);
    chk(ord_ok, "R3", "order of output changes", ord_ok, 1);
    if (exp_res == 1) begin
      chk(safe_word() == RUN_W, "R7", "output word on success", safe_word(), RUN_W);
      chk(lo_smp == dly + 1, "R4", "request low cycles", lo_smp, dly + 1);
    end else begin
      chk(safe_word() == SAFE_W, "R8", "output word on failure", safe_word(), SAFE_W);
    end
    r_seen = res;
    @(negedge clk);
    chk(done == 0, "R9", "done one cycle", done, 0);
    @(negedge clk);
    chk(int'(res) == r_seen && !busy, "R9", "result held", res, r_seen);
    ncfg_low_k = 0; stat_low_k = 0; hi_stuck_k = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cdone_pin = 0; cdone_oe = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(safe_word() == SAFE_W, "R10", "outputs after reset", safe_word(), SAFE_W);
    chk(!busy && !done && res == 3'd0, "R10", "status after reset", {busy, done, res}, 0);

    // R1: mode-select sweep
    for (int m = 0; m < (1 << MW); m++)
      run(m, 3, 0, 0, 0, 0, 1, 0, (m <= 1) ? 1 : 2, (m <= 1) ? 11 : 0, "R1");

    // R4 / R7: response delay sweep across the timeout boundary
    for (int d = 0; d <= TO; d++)
      run(0, d, 0, 0, 0, 0, 1, 0, (d < TO) ? 1 : 3, (d < TO) ? d + 8 : TO + 5,
          (d < TO) ? "R7" : "R4");

    // R2: either line held low blocks progress
    run(1, 2, 1, 0, 0, 0, 1, 0, 3, TO, "R2");
    run(1, 2, 0, 1, 0, 0, 1, 0, 3, TO, "R2");

    // R5: status never returns high
    run(0, 2, 0, 0, 1, 0, 1, 0, 3, 2 + TO + 6, "R5");

    // R6: done pin / output-enable combinations
    for (int c = 0; c < 4; c++)
      run(0, 1, 0, 0, 0, c[1], c[0], 0, (c == 1) ? 1 : 4, 9, "R6");

    // R9: start while busy is ignored
    run(0, 4, 0, 0, 0, 0, 1, 1, 1, 12, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule